// File: doc/BRIEF.md
# Pin Bank with Per-Pin Interrupt Detection

This block is one bank of 32 general-purpose pins behind a small word-addressed register interface with an address, a write enable, write data and combinational read data. Software sets an output value and a direction for each pin. It reads back the pad levels after they pass a two-stage synchronizer.

Each pin also has an interrupt detector. A two-bit trigger code per pin selects a low level, a high level, a rising edge or a falling edge. A separate per-pin override makes the pin fire on either edge. Detected events latch into a status word, and software clears that word by writing ones. A mask word gates the status into two interrupt lines: one collects pins 0 to 15 and the other collects pins 16 to 31.

Registers sit on 4-byte boundaries. An access at an address that is not a multiple of four, or that lies above the eight defined words, writes nothing and reads zero.

Top module: `gpio_irq_port`

## Requirements
- R1: The registers sit at these byte offsets: output data 0x00, direction 0x04, pad level 0x08, trigger config for pins 0-15 at 0x0C, trigger config for pins 16-31 at 0x10, mask 0x14, status 0x18, both-edge select 0x1C. A write to one offset changes only that register. Every writable register reads back its last written value.
- R2: `padOut` always carries the output data word. A direction bit of 1 drives `padOe` high for that pin, and a direction bit of 0 drives it low.
- R3: Reading offset 0x00 returns the written output word and not the pad levels. Reading offset 0x08 returns `padIn` delayed by two clock edges.
- R4: Pin n takes its 2-bit trigger code from bits [2*(n mod 16)+1 : 2*(n mod 16)] of the config word for its half. The codes are: 0 fires while the synchronized level is low, 1 fires while it is high, 2 fires on a rising edge, 3 fires on a falling edge.
- R5: An edge code sets the pin's status bit once, on the matching transition of the synchronized input. The opposite transition does not set it.
- R6: When a pin's both-edge bit is 1, either transition sets its status bit and its trigger code has no effect, level codes included.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it as it was.
- R8: A level condition sets its status bit again on every cycle it holds. If a set and a clear hit the same bit in one cycle, the set wins.
- R9: `irqLow` is high exactly when some pin in 0-15 has both its status bit and its mask bit at 1. `irqHigh` follows the same rule for pins 16-31.
- R10: After reset, the data, direction, config, mask and both-edge registers are zero. So every pin is an input and both interrupt lines are low.
- R11: A write to the pad level offset 0x08 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register access |
| busWe | input | 1 | Write strobe, sampled at the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register, combinational |
| padIn | input | 32 | Raw pad input levels |
| padOut | output | 32 | Output value for each pin |
| padOe | output | 32 | Output enable for each pin, 1 = drive |
| irqLow | output | 1 | Interrupt request from pins 0-15 |
| irqHigh | output | 1 | Interrupt request from pins 16-31 |

## Verification
The assertions check status-word bookkeeping on every cycle: a cleared bit that is not being set reads zero one cycle later, a bit does not drop without a clear, a same-cycle set always wins over a clear, and both lines stay quiet while the mask is zero. The assertions also check that at most one register write strobe fires at a time. Only the bench scenarios can show the trigger-code selection and its field positions, the edge-direction filtering, the both-edge override silencing a level code, the two-cycle pad latency, and the routing of each half to its own interrupt line.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register index, equal to byte offset / 4; the order fixes the address map.
  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_PAD   = 3'd2,
    SEL_CFGLO = 3'd3,
    SEL_CFGHI = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_EDGE  = 3'd7
  } regSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrStat;
    logic    wrEdge;
    logic    rdHit;
    regSel_e rdSel;
  } regStrobe_t;

  // Trigger codes.
  localparam logic [1:0] TRIG_LOW  = 2'd0;
  localparam logic [1:0] TRIG_HIGH = 2'd1;
  localparam logic [1:0] TRIG_RISE = 2'd2;
  localparam logic [1:0] TRIG_FALL = 2'd3;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strobe
);

  localparam int WORD_LSB = 2;
  localparam int SEL_W    = 3;
  localparam int TOP_LSB  = WORD_LSB + SEL_W;

  logic    aligned;
  logic    upperZero;
  logic    hit;
  regSel_e sel;

  assign aligned = (busAddr[WORD_LSB-1:0] == '0);

  generate
    if (ADDR_W > TOP_LSB) begin : g_upper
      assign upperZero = (busAddr[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign hit = aligned && upperZero;
  assign sel = regSel_e'(busAddr[WORD_LSB +: SEL_W]);

  always_comb begin
    strobe         = '0;
    strobe.rdHit   = hit;
    strobe.rdSel   = sel;
    if (busWe && hit) begin
      unique case (sel)
        SEL_DATA:  strobe.wrData  = 1'b1;
        SEL_DIR:   strobe.wrDir   = 1'b1;
        SEL_CFGLO: strobe.wrCfgLo = 1'b1;
        SEL_CFGHI: strobe.wrCfgHi = 1'b1;
        SEL_MASK:  strobe.wrMask  = 1'b1;
        SEL_STAT:  strobe.wrStat  = 1'b1;
        SEL_EDGE:  strobe.wrEdge  = 1'b1;
        default:   ;  // pad level word is read-only (R11)
      endcase
    end
  end

  // R1: one access reaches at most one register.
  assert_one_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrData, strobe.wrDir, strobe.wrCfgLo, strobe.wrCfgHi,
              strobe.wrMask, strobe.wrStat, strobe.wrEdge}));

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] curLvl,
  input  logic [NUM_PINS-1:0] prevLvl,
  input  logic [NUM_PINS-1:0] cfgLo,
  input  logic [NUM_PINS-1:0] cfgHi,
  input  logic [NUM_PINS-1:0] bothEdge,
  output logic [NUM_PINS-1:0] setVec
);

  localparam int HALF = NUM_PINS / 2;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int FLD = 2 * (p % HALF);
    logic [1:0] code;
    logic       rise;
    logic       fall;
    logic       codeHit;

    if (p < HALF) begin : g_lo
      assign code = cfgLo[FLD +: 2];
    end else begin : g_hi
      assign code = cfgHi[FLD +: 2];
    end

    assign rise = curLvl[p] & ~prevLvl[p];
    assign fall = ~curLvl[p] & prevLvl[p];

    always_comb begin
      unique case (code)
        TRIG_LOW:  codeHit = ~curLvl[p];
        TRIG_HIGH: codeHit = curLvl[p];
        TRIG_RISE: codeHit = rise;
        default:   codeHit = fall;
      endcase
    end

    // R6: both-edge select overrides the code.
    assign setVec[p] = bothEdge[p] ? (rise | fall) : codeHit;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh
);

  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ, maskQ, edgeQ, statusQ;
  logic [NUM_PINS-1:0] sync1Q, syncQ, prevQ;
  logic [NUM_PINS-1:0] setVec, clrVec, reqVec;

  // Configuration registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '0;
      edgeQ  <= '0;
    end else begin
      if (strobe.wrData)  dataQ  <= busWdata;
      if (strobe.wrDir)   dirQ   <= busWdata;
      if (strobe.wrCfgLo) cfgLoQ <= busWdata;
      if (strobe.wrCfgHi) cfgHiQ <= busWdata;
      if (strobe.wrMask)  maskQ  <= busWdata;
      if (strobe.wrEdge)  edgeQ  <= busWdata;
    end
  end

  // Two-flop synchronizer plus a history stage for edge detection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1Q <= '0;
      syncQ  <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= padIn;
      syncQ  <= sync1Q;
      prevQ  <= syncQ;
    end
  end

  gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .curLvl   (syncQ),
    .prevLvl  (prevQ),
    .cfgLo    (cfgLoQ),
    .cfgHi    (cfgHiQ),
    .bothEdge (edgeQ),
    .setVec   (setVec)
  );

  // Status: write-one-to-clear, a same-cycle set wins.
  assign clrVec = strobe.wrStat ? busWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrVec) | setVec;
  end

  assign reqVec  = statusQ & maskQ;
  assign irqLow  = |reqVec[HALF-1:0];
  assign irqHigh = |reqVec[NUM_PINS-1:HALF];

  assign padOut = dataQ;
  assign padOe  = dirQ;

  always_comb begin
    busRdata = '0;
    if (strobe.rdHit) begin
      unique case (strobe.rdSel)
        SEL_DATA:  busRdata = dataQ;
        SEL_DIR:   busRdata = dirQ;
        SEL_PAD:   busRdata = syncQ;
        SEL_CFGLO: busRdata = cfgLoQ;
        SEL_CFGHI: busRdata = cfgHiQ;
        SEL_MASK:  busRdata = maskQ;
        SEL_STAT:  busRdata = statusQ;
        default:   busRdata = edgeQ;
      endcase
    end
  end

  // R7: a bit cleared without a concurrent set reads zero next cycle.
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(clrVec & ~setVec)) == '0));

  // R7: no status bit drops unless it was written with a one.
  assert_status_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusQ & ~clrVec) & ~statusQ) == '0));

  // R8: every detected event is latched, even against a clear.
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(setVec)) == $past(setVec)));

  // R9: an all-zero mask keeps both lines low.
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> (!irqLow && !irqHigh));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh
);

  regStrobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  gpio_port_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh)
  );

endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = 32'hFFFF_FFFF;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic        irqLow;
  logic        irqHigh;

  int total = 0;
  int bad = 0;

  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                         A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14,
                         A_STAT = 5'h18, A_EDGE = 5'h1C;

  always #10 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic expectReg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pads(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 data", u_dut.padOut, 32'h0);
    check("R10 oe", padOe, 32'h0);
    check("R10 irq", {30'h0, irqHigh, irqLow}, 32'h0);
    expectReg("R10 dir", A_DIR, 32'h0);
    expectReg("R10 mask", A_MASK, 32'h0);
    expectReg("R10 edge", A_EDGE, 32'h0);
    expectReg("R10 cfglo", A_CLO, 32'h0);
    repeat (4) @(negedge clk);
    wr(A_STAT, 32'hFFFF_FFFF);
    expectReg("R7 clear all", A_STAT, 32'h0);
  endtask

  task automatic testDirection();
    logic [31:0] v;
    wr(A_DATA, 32'hA5A5_0F0F);
    wr(A_DIR, 32'hFFFF_0000);
    check("R2 oe", padOe, 32'hFFFF_0000);
    check("R2 out", padOut, 32'hA5A5_0F0F);
    expectReg("R3 data not pads", A_DATA, 32'hA5A5_0F0F);
    expectReg("R3 pads", A_PAD, 32'hFFFF_FFFF);
    // Pad change: new value seen after two edges.
    @(negedge clk);
    padIn = 32'hFFFF_00FF;
    busAddr = A_PAD;
    @(negedge clk);
    #1 v = busRdata;
    check("R3 one edge", v, 32'hFFFF_FFFF);
    @(negedge clk);
    #1 v = busRdata;
    check("R3 two edges", v, 32'hFFFF_00FF);
    pads(32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic testReadOnly();
    wr(A_PAD, 32'h1234_5678);
    expectReg("R11 data", A_DATA, 32'hA5A5_0F0F);
    expectReg("R11 dir", A_DIR, 32'hFFFF_0000);
    expectReg("R11 mask", A_MASK, 32'h0);
    expectReg("R11 status", A_STAT, 32'h0);
  endtask

  task automatic testConfig();
    wr(A_CLO, 32'h0000_0080);  // pin 3 rising
    wr(A_CHI, 32'h0000_0300);  // pin 20 falling
    wr(A_MASK, 32'h0);
    expectReg("R1 cfglo", A_CLO, 32'h0000_0080);
    expectReg("R1 cfghi", A_CHI, 32'h0000_0300);
    expectReg("R1 data kept", A_DATA, 32'hA5A5_0F0F);
  endtask

  task automatic testEdges();
    wr(A_STAT, 32'hFFFF_FFFF);
    pads(32'hFFFF_FFF7);
    expectReg("R5 fall ignored on rise code", A_STAT, 32'h0);
    pads(32'hFFFF_FFFF);
    expectReg("R5 rise pin3", A_STAT, 32'h0000_0008);
    pads(32'hFFEF_FFFF);
    expectReg("R4 fall pin20 high word", A_STAT, 32'h0010_0008);
    pads(32'hFFFF_FFFF);
    expectReg("R5 rise ignored on fall code", A_STAT, 32'h0010_0008);
  endtask

  task automatic testClear();
    wr(A_STAT, 32'h0);
    expectReg("R7 zero write", A_STAT, 32'h0010_0008);
    wr(A_STAT, 32'h0000_0008);
    expectReg("R7 one bit cleared", A_STAT, 32'h0010_0000);
  endtask

  task automatic testIrq();
    check("R9 masked", {30'h0, irqHigh, irqLow}, 32'h0);
    wr(A_MASK, 32'h0010_0000);
    check("R9 high half", {30'h0, irqHigh, irqLow}, 32'h2);
    pads(32'hFFFF_FFF7);
    pads(32'hFFFF_FFFF);
    check("R9 low bit unmasked", {30'h0, irqHigh, irqLow}, 32'h2);
    wr(A_MASK, 32'h0010_0008);
    check("R9 both", {30'h0, irqHigh, irqLow}, 32'h3);
    wr(A_STAT, 32'h0010_0000);
    check("R9 low only", {30'h0, irqHigh, irqLow}, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_MASK, 32'h0);
  endtask

  task automatic testLevel();
    wr(A_CLO, 32'h0000_4080);  // pin 7 high level
    repeat (2) @(negedge clk);
    expectReg("R4 high level pin7", A_STAT, 32'h0000_0080);
    wr(A_STAT, 32'h0000_0080);
    expectReg("R8 set beats clear", A_STAT, 32'h0000_0080);
    wr(A_CLO, 32'h0000_0080);
    wr(A_STAT, 32'hFFFF_FFFF);
    expectReg("R7 level gone", A_STAT, 32'h0);
    pads(32'hFFFF_FFDF);
    expectReg("R4 low level pin5", A_STAT, 32'h0000_0020);
    wr(A_STAT, 32'h0000_0020);
    expectReg("R8 low level rearms", A_STAT, 32'h0000_0020);
    pads(32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF);
    expectReg("R7 after release", A_STAT, 32'h0);
  endtask

  task automatic testBoth();
    wr(A_EDGE, 32'h0000_0028);
    expectReg("R1 edge readback", A_EDGE, 32'h0000_0028);
    pads(32'hFFFF_FFF7);
    expectReg("R6 fall on rise-coded pin", A_STAT, 32'h0000_0008);
    wr(A_STAT, 32'hFFFF_FFFF);
    pads(32'hFFFF_FFFF);
    expectReg("R6 rise", A_STAT, 32'h0000_0008);
    wr(A_STAT, 32'hFFFF_FFFF);
    pads(32'hFFFF_FFDF);
    expectReg("R6 fall on level pin", A_STAT, 32'h0000_0020);
    wr(A_STAT, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    expectReg("R6 level code ignored", A_STAT, 32'h0);
    pads(32'hFFFF_FFFF);
    expectReg("R6 rise on level pin", A_STAT, 32'h0000_0020);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDirection();
    testReadOnly();
    testConfig();
    testEdges();
    testClear();
    testIrq();
    testLevel();
    testBoth();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule